// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

This block merges eight interrupt request lines into one interrupt output to a host. Each input latches a request on a rising edge. Requests are then filtered by a mask register and ranked by fixed priority: input 0 is the highest and input 7 the lowest. A request is forwarded only if it outranks every level the host is already servicing. The host can take the winning request in two ways. It can run a hardware acknowledge, which returns an 8-bit vector. Or it can issue a poll command, after which the next register read both returns and acknowledges the winning level. End-of-interrupt commands release the in-service levels afterwards.

The host reaches all state through a byte-wide port with a single address bit. After reset, an initialization word on the even address starts a short sequence on the odd address. That sequence loads the vector base, then a cascade word, then an optional mode word. Once it is complete, odd-address traffic reaches the mask register. Even-address writes carry commands, and even-address reads return the pending-request register, the in-service register or a poll result.

Two instances can be chained. A pin selects the master or slave role. A master with a slave attached to one of its inputs names that slave on the cascade lines during an acknowledge, and the slave whose programmed identity matches supplies the vector.

Top module: `cascade_pic`

## Requirements
- R1: After reset the mask register reads 0xFF on the odd address, the pending-request register reads 0x00 on the even address, and `int_out` is low.
- R2: An even-address write with bit 4 set starts initialization. Bit 1 of that word set means there is no cascade word, and bit 0 set means a mode word follows. The next odd-address writes are then taken in this order: vector base, cascade word (if expected), mode word (if expected). Only after the sequence ends do odd-address writes load the mask, and odd-address reads always return the mask.
- R3: A rising edge on an input records a request. The request is dropped if the input falls before it is acknowledged, and it is cleared when it is acknowledged. An input that stays high does not raise a new request.
- R4: Priority is fixed, with input 0 highest. `int_out` is high exactly when some unmasked recorded request has a higher priority than every set in-service bit.
- R5: A mask bit of 1 blocks its input from `int_out` and from acknowledge, while the request itself stays recorded and readable.
- R6: On a hardware acknowledge (`inta` high for one cycle) with a request to grant, `vec_valid` is high in that cycle. `vec_out` is the upper five bits of the vector base joined to the 3-bit level, and that level's in-service bit is set.
- R7: Writing 0x0C to the even address arms a poll. On the next even-address read, if a request is granted, the read returns bit 7 set with the level in bits 2:0 and sets that in-service bit. If nothing is granted, it returns 0x00 and changes nothing.
- R8: Writing 0x0B to the even address makes later even-address reads return the in-service register, and writing 0x0A returns them to the pending-request register. The choice persists across reads.
- R9: Writing 0x20 to the even address clears the highest-priority set in-service bit.
- R10: Writing 0x60 plus a level L (0 to 7) to the even address clears in-service bit L.
- R11: A hardware acknowledge with nothing to grant returns the vector for level 7 and leaves the in-service register unchanged. This includes the case of a request on input 7 that vanished before the acknowledge, so in-service bit 7 stays clear.
- R12: In the master role (`slave_sel` low), granting an input whose cascade-word bit is set drives that level on `cas_out` with `cas_drive` high and keeps `vec_valid` low. A slave (`slave_sel` high) acts on `inta` only when `cas_in` equals bits 2:0 of its cascade word; otherwise it stays silent and unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_sel | input | 1 | 1 = slave role, 0 = master role |
| reg_sel | input | 1 | Register port address bit (0 even, 1 odd) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, valid while rd_en is high |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the host |
| inta | input | 1 | Hardware acknowledge, one cycle per acknowledge |
| vec_out | output | 8 | Vector returned during acknowledge |
| vec_valid | output | 1 | This instance supplies vec_out now |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_drive | output | 1 | Master is driving cas_out |

## Verification
The assertions assume that `inta`, register writes and even-address reads never occur in the same cycle. They also assume that `inta` lasts exactly one cycle, and that a slave's `cas_in` comes from its master's `cas_out`. The stimulus tasks drive one of these strobes at a time, each for one full cycle, and tie the slave's cascade input to the master's output. Random masks and request patterns stay clear of the cascade input while the slave is idle, so the expected vector depends only on the master.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_IN = 8;
    localparam int LVL_W  = $clog2(NUM_IN);
    localparam int DW     = 8;
    localparam int BASE_W = DW - LVL_W;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_BASE,
        PH_CASC,
        PH_MODE
    } init_ph_e;

    typedef struct packed {
        logic [NUM_IN-1:0] mask;
        logic [NUM_IN-1:0] irr;
        logic [NUM_IN-1:0] isr;
        logic [NUM_IN-1:0] prev;
        init_ph_e          ph;
        logic [BASE_W-1:0] base;
        logic [DW-1:0]     casc;
        logic              need_mode;
        logic              single;
        logic              rd_isr;
        logic              poll;
    } pic_state_t;

    localparam logic [2:0] EOI_ANY  = 3'b001;
    localparam logic [2:0] EOI_LVL  = 3'b011;
    localparam int         BIT_INIT = 4;
    localparam int         BIT_CMD3 = 3;
    localparam int         BIT_POLL = 2;
    localparam int         BIT_RSEL = 1;
endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
    parameter int N = 8
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = cur[i] & ~prev[i];
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  blk,
    output logic          hit,
    output logic [LW-1:0] lvl
);
    logic          req_any;
    logic          blk_any;
    logic [LW-1:0] req_lvl;
    logic [LW-1:0] blk_lvl;

    always_comb begin
        req_any = 1'b0;
        req_lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                req_any = 1'b1;
                req_lvl = LW'(i);
            end
        end
    end

    always_comb begin
        blk_any = 1'b0;
        blk_lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (blk[i]) begin
                blk_any = 1'b1;
                blk_lvl = LW'(i);
            end
        end
    end

    assign hit = req_any && (!blk_any || (req_lvl < blk_lvl));
    assign lvl = req_lvl;
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_sel,
    input  logic          reg_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic          int_out,
    input  logic          inta,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid,
    input  logic [LVL_W-1:0] cas_in,
    output logic [LVL_W-1:0] cas_out,
    output logic          cas_drive
);
    pic_state_t st_q, st_d;

    logic [NUM_IN-1:0] rise;
    logic [NUM_IN-1:0] pend;
    logic              g_hit, t_hit;
    logic [LVL_W-1:0]  g_lvl, t_lvl;
    logic              id_match, hw_ack, poll_rd, even_rd, take, casc_grant;

    // signals seen by the bound checker
    logic [NUM_IN-1:0] isr_w, irr_w, mask_w;
    logic              run_w;
    assign isr_w  = st_q.isr;
    assign irr_w  = st_q.irr;
    assign mask_w = st_q.mask;
    assign run_w  = (st_q.ph == PH_RUN);

    pic_edge_det #(.N(NUM_IN)) u_edge (
        .cur  (irq_in),
        .prev (st_q.prev),
        .rise (rise)
    );

    assign pend = st_q.irr & ~st_q.mask;

    pic_prio #(.N(NUM_IN), .LW(LVL_W)) u_grant (
        .req (pend),
        .blk (st_q.isr),
        .hit (g_hit),
        .lvl (g_lvl)
    );

    pic_prio #(.N(NUM_IN), .LW(LVL_W)) u_top (
        .req (st_q.isr),
        .blk ('0),
        .hit (t_hit),
        .lvl (t_lvl)
    );

    assign id_match   = slave_sel ? (cas_in == st_q.casc[LVL_W-1:0]) : 1'b1;
    assign hw_ack     = inta && id_match;
    assign even_rd    = rd_en && !reg_sel;
    assign poll_rd    = even_rd && st_q.poll;
    assign take       = (poll_rd || hw_ack) && g_hit;
    assign casc_grant = !slave_sel && g_hit && st_q.casc[g_lvl];

    assign int_out   = g_hit;
    assign cas_drive = inta && casc_grant;
    assign cas_out   = cas_drive ? g_lvl : '0;
    assign vec_valid = hw_ack && !casc_grant;
    assign vec_out   = vec_valid ? {st_q.base, (g_hit ? g_lvl : LVL_W'(NUM_IN - 1))} : '0;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (reg_sel)
                rdata = st_q.mask;
            else if (st_q.poll)
                rdata = {g_hit, {(DW-LVL_W-1){1'b0}}, (g_hit ? g_lvl : LVL_W'(0))};
            else if (st_q.rd_isr)
                rdata = st_q.isr;
            else
                rdata = st_q.irr;
        end
    end

    always_comb begin
        logic [NUM_IN-1:0] irr_n;
        logic [NUM_IN-1:0] isr_n;
        st_d      = st_q;
        st_d.prev = irq_in;
        irr_n     = (st_q.irr | rise) & irq_in;
        isr_n     = st_q.isr;

        if (take) begin
            irr_n[g_lvl] = 1'b0;
            isr_n[g_lvl] = 1'b1;
        end
        if (even_rd)
            st_d.poll = 1'b0;

        if (wr_en && !reg_sel) begin
            if (wdata[BIT_INIT]) begin
                st_d.ph        = PH_BASE;
                st_d.single    = wdata[1];
                st_d.need_mode = wdata[0];
                st_d.rd_isr    = 1'b0;
                st_d.poll      = 1'b0;
                irr_n          = '0;
                isr_n          = '0;
            end else if (wdata[BIT_CMD3]) begin
                if (wdata[BIT_RSEL])
                    st_d.rd_isr = wdata[0];
                if (wdata[BIT_POLL])
                    st_d.poll = 1'b1;
            end else begin
                if (wdata[7:5] == EOI_ANY) begin
                    if (t_hit)
                        isr_n[t_lvl] = 1'b0;
                end else if (wdata[7:5] == EOI_LVL) begin
                    isr_n[wdata[LVL_W-1:0]] = 1'b0;
                end
            end
        end

        if (wr_en && reg_sel) begin
            unique case (st_q.ph)
                PH_RUN: st_d.mask = wdata;
                PH_BASE: begin
                    st_d.base = wdata[DW-1:LVL_W];
                    if (!st_q.single)
                        st_d.ph = PH_CASC;
                    else if (st_q.need_mode)
                        st_d.ph = PH_MODE;
                    else
                        st_d.ph = PH_RUN;
                end
                PH_CASC: begin
                    st_d.casc = wdata;
                    st_d.ph   = st_q.need_mode ? PH_MODE : PH_RUN;
                end
                PH_MODE: st_d.ph = PH_RUN;
                default: st_d.ph = PH_RUN;
            endcase
        end

        st_d.irr = irr_n;
        st_d.isr = isr_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mask      <= '1;
            st_q.ph        <= PH_RUN;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       slave_sel,
    input logic       reg_sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic       inta,
    input logic       int_out,
    input logic       vec_valid,
    input logic       cas_drive,
    input logic [7:0] isr,
    input logic [7:0] irr,
    input logic [7:0] mask,
    input logic       run
);
    // R5 / R4: interrupt only with an unmasked recorded request
    a_r5_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != 8'h00));

    // R2: mask loads only once initialization has finished
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && run) |=> (mask == $past(wdata)));

    // R6: a granted master acknowledge adds exactly one in-service bit
    a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !slave_sel && !wr_en && !rd_en)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R9: non-specific end of interrupt removes exactly one bit
    a_r9_eoi_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wdata == 8'h20 && isr != 8'h00 && !inta && !rd_en)
        |=> ($countones(isr) + 1 == $countones($past(isr))));

    // R11: an acknowledge with nothing to grant leaves in-service unchanged
    a_r11_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out && !wr_en && !rd_en) |=> (isr == $past(isr)));

    // R12: master never supplies a vector while naming a slave
    a_r12_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        cas_drive |-> !vec_valid);
endmodule

bind cascade_pic pic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_sel (slave_sel),
    .reg_sel   (reg_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .inta      (inta),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .cas_drive (cas_drive),
    .isr       (isr_w),
    .irr       (irr_w),
    .mask      (mask_w),
    .run       (run_w)
);

// File: tb/cascade_pic_test.sv
module cascade_pic_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       bus_sel = 1'b0;
    logic [7:0] bus_d = 8'h00;
    logic       m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic       inta = 1'b0;
    logic [7:0] m_in = 8'h00, s_in = 8'h00;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
    logic       m_int, s_int, m_vv, s_vv, m_cd, s_cd;
    logic [2:0] m_co, s_co;
    logic [7:0] m_irq;

    int n_chk = 0;
    int n_fail = 0;

    assign m_irq = {m_in[7:3], s_int, m_in[1:0]};

    cascade_pic uut (
        .clk(clk), .rst_n(rst_n), .slave_sel(1'b0), .reg_sel(bus_sel),
        .wr_en(m_wr), .rd_en(m_rd), .wdata(bus_d), .rdata(m_rdata),
        .irq_in(m_irq), .int_out(m_int), .inta(inta), .vec_out(m_vec),
        .vec_valid(m_vv), .cas_in(3'd0), .cas_out(m_co), .cas_drive(m_cd)
    );

    cascade_pic uut_slave (
        .clk(clk), .rst_n(rst_n), .slave_sel(1'b1), .reg_sel(bus_sel),
        .wr_en(s_wr), .rd_en(s_rd), .wdata(bus_d), .rdata(s_rdata),
        .irq_in(s_in), .int_out(s_int), .inta(inta), .vec_out(s_vec),
        .vec_valid(s_vv), .cas_in(m_co), .cas_out(s_co), .cas_drive(s_cd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit s, input bit a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = a; bus_d = d;
        if (s) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input bit s, input bit a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = a;
        if (s) s_rd = 1'b1; else m_rd = 1'b1;
        #1 v = s ? s_rdata : m_rdata;
        @(negedge clk);
        m_rd = 1'b0; s_rd = 1'b0;
    endtask

    task automatic read_isr(input bit s, output logic [7:0] v);
        wr(s, 1'b0, 8'h0B);
        rd(s, 1'b0, v);
        wr(s, 1'b0, 8'h0A);
    endtask

    task automatic ack();
        @(negedge clk);
        inta = 1'b1;
        #1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    logic [7:0] a_mvec, a_svec;
    logic       a_mvv, a_svv, a_mcd;
    logic [2:0] a_mco;

    task automatic ack_cap();
        @(negedge clk);
        inta = 1'b1;
        #1;
        a_mvec = m_vec; a_svec = s_vec; a_mvv = m_vv; a_svv = s_vv;
        a_mcd = m_cd; a_mco = m_co;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] win(input logic [7:0] p);
        for (int i = 0; i < 8; i++)
            if (p[i]) return {1'b1, 3'(i)};
        return 4'h0;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 1'b1, v); chk("R1 mask", v, 8'hFF);
        rd(0, 1'b0, v); chk("R1 irr", v, 8'h00);
        chk("R1 int_out", {7'b0, m_int}, 8'h00);

        // R2 initialization sequence (mask untouched mid-sequence)
        wr(0, 1'b0, 8'h11);
        wr(0, 1'b1, 8'h20);
        rd(0, 1'b1, v); chk("R2 mask during init", v, 8'hFF);
        wr(0, 1'b1, 8'h04);
        wr(0, 1'b1, 8'h01);
        wr(0, 1'b1, 8'h00);
        rd(0, 1'b1, v); chk("R2 mask after init", v, 8'h00);
        wr(1, 1'b0, 8'h11);
        wr(1, 1'b1, 8'h28);
        wr(1, 1'b1, 8'h02);
        wr(1, 1'b1, 8'h01);
        wr(1, 1'b1, 8'h00);
        rd(1, 1'b1, v); chk("R2 slave mask", v, 8'h00);

        // R4 nesting, R6 vectors, R3 clear on ack, R8/R9/R10
        @(negedge clk); m_in = 8'h20; idle(2);
        chk("R4 int on single req", {7'b0, m_int}, 8'h01);
        ack_cap(); chk("R6 vector lvl5", a_mvec, 8'h25); chk("R6 valid", {7'b0, a_mvv}, 8'h01);
        rd(0, 1'b0, v); chk("R3 cleared by ack while high", v, 8'h00);
        @(negedge clk); m_in = 8'h60; idle(2);
        chk("R4 lower prio held off", {7'b0, m_int}, 8'h00);
        @(negedge clk); m_in = 8'h62; idle(2);
        chk("R4 higher prio passes", {7'b0, m_int}, 8'h01);
        ack_cap(); chk("R6 vector lvl1", a_mvec, 8'h21);
        wr(0, 1'b0, 8'h0B);
        rd(0, 1'b0, v); chk("R8 isr read", v, 8'h22);
        rd(0, 1'b0, v); chk("R8 isr persists", v, 8'h22);
        wr(0, 1'b0, 8'h20);
        rd(0, 1'b0, v); chk("R9 nonspecific eoi", v, 8'h20);
        chk("R4 still blocked by lvl5", {7'b0, m_int}, 8'h00);
        wr(0, 1'b0, 8'h65);
        rd(0, 1'b0, v); chk("R10 specific eoi", v, 8'h00);
        chk("R4 lvl6 now passes", {7'b0, m_int}, 8'h01);
        ack_cap(); chk("R6 vector lvl6", a_mvec, 8'h26);
        wr(0, 1'b0, 8'h20);
        wr(0, 1'b0, 8'h0A);
        rd(0, 1'b0, v); chk("R8 back to irr", v, 8'h00);
        @(negedge clk); m_in = 8'h00;

        // R3 request dropped before ack
        @(negedge clk); m_in = 8'h10; idle(1);
        m_in = 8'h00; idle(2);
        rd(0, 1'b0, v); chk("R3 dropped request", v, 8'h00);
        chk("R3 no int", {7'b0, m_int}, 8'h00);

        // R5 mask
        wr(0, 1'b1, 8'h08);
        @(negedge clk); m_in = 8'h08; idle(2);
        chk("R5 masked no int", {7'b0, m_int}, 8'h00);
        rd(0, 1'b0, v); chk("R5 still recorded", v, 8'h08);
        wr(0, 1'b1, 8'h00); idle(1);
        chk("R5 unmasked int", {7'b0, m_int}, 8'h01);
        ack_cap(); chk("R5 vector", a_mvec, 8'h23);
        wr(0, 1'b0, 8'h20);
        @(negedge clk); m_in = 8'h00;

        // R7 poll
        @(negedge clk); m_in = 8'h18; idle(2);
        wr(0, 1'b0, 8'h0C);
        rd(0, 1'b0, v); chk("R7 poll lvl3", v, 8'h83);
        read_isr(0, v); chk("R7 poll sets isr", v, 8'h08);
        wr(0, 1'b0, 8'h20);
        wr(0, 1'b0, 8'h0C);
        rd(0, 1'b0, v); chk("R7 poll lvl4", v, 8'h84);
        wr(0, 1'b0, 8'h20);
        @(negedge clk); m_in = 8'h00;
        wr(0, 1'b0, 8'h0C);
        rd(0, 1'b0, v); chk("R7 poll empty", v, 8'h00);
        read_isr(0, v); chk("R7 empty poll no isr", v, 8'h00);

        // R11 spurious on input 7
        @(negedge clk); m_in = 8'h80; idle(2);
        chk("R11 int seen", {7'b0, m_int}, 8'h01);
        @(negedge clk); m_in = 8'h00; idle(2);
        ack_cap();
        chk("R11 spurious vector", a_mvec, 8'h27);
        chk("R11 spurious valid", {7'b0, a_mvv}, 8'h01);
        read_isr(0, v); chk("R11 isr7 clear", v, 8'h00);

        // R12 cascade through slave id 2
        @(negedge clk); s_in = 8'h08; idle(4);
        chk("R12 master int", {7'b0, m_int}, 8'h01);
        ack_cap();
        chk("R12 cas_drive", {7'b0, a_mcd}, 8'h01);
        chk("R12 cas_out", {5'b0, a_mco}, 8'h02);
        chk("R12 master silent", {7'b0, a_mvv}, 8'h00);
        chk("R12 slave valid", {7'b0, a_svv}, 8'h01);
        chk("R12 slave vector", a_svec, 8'h2B);
        wr(1, 1'b0, 8'h20);
        wr(0, 1'b0, 8'h20);
        @(negedge clk); s_in = 8'h00; idle(2);

        @(negedge clk); s_in = 8'h10; m_in = 8'h01; idle(4);
        ack_cap();
        chk("R12 master own vector", a_mvec, 8'h20);
        chk("R12 slave not addressed", {7'b0, a_svv}, 8'h00);
        chk("R12 no cascade drive", {7'b0, a_mcd}, 8'h00);
        read_isr(1, v); chk("R12 slave isr unchanged", v, 8'h00);
        wr(0, 1'b0, 8'h20); idle(1);
        ack_cap();
        chk("R12 second cascade drive", {7'b0, a_mcd}, 8'h01);
        chk("R12 slave vector lvl4", a_svec, 8'h2C);
        wr(1, 1'b0, 8'h20);
        wr(0, 1'b0, 8'h20);
        @(negedge clk); s_in = 8'h00; m_in = 8'h00; idle(3);

        // random masks and request patterns (cascade input left idle)
        for (int it = 0; it < 24; it++) begin
            logic [7:0] rm, rq, pend;
            logic [3:0] w;
            rm = 8'($urandom);
            rq = 8'($urandom) & 8'hFB;
            pend = rq & ~rm;
            w = win(pend);
            wr(0, 1'b1, rm);
            @(negedge clk); m_in = rq; idle(2);
            rd(0, 1'b0, v); chk("R3 random irr", v, rq);
            chk("R5 random int", {7'b0, m_int}, {7'b0, w[3]});
            ack_cap();
            chk("R6 random vector", a_mvec, w[3] ? {5'b00100, w[2:0]} : 8'h27);
            if (w[3]) wr(0, 1'b0, 8'h20);
            @(negedge clk); m_in = 8'h00; idle(1);
            read_isr(0, v); chk("R9 random isr empty", v, 8'h00);
        end

        finish_run();
    end
endmodule